// File: doc/BRIEF.md
# Video Blank, Sync and Pedestal Level Inserter

This block sits just before the video DACs. It turns blanked video samples into DAC codes by adding three things: the blanking offset, a sync tip level that moves along a short linear ramp, and an optional setup (pedestal) offset. It does this for a three-channel component output and for the luma of a composite output. The component path takes its blank and sync codes from a ratio-select bit. The composite path takes them from the video format. Upstream logic supplies the sync and blank timing flags, the field identifier and the line number.

The output mode decides which component channels receive offsets. The mode can be luma plus colour difference, RGB with sync carried on green, or RGB with sync sent on a separate wire. The pedestal enable is sampled only on a fixed start line of each field and then held for the rest of that field. The pedestal has a separate signed height for each path. Every output is registered and is held within the code range 0 to 1023.

Top module: `vbs_level_inserter`

## Requirements
- R1: While `rst_n` is low, all four DAC outputs read 0. After reset, each output reflects the inputs present at the previous rising clock edge, so the block has one cycle of latency.
- R2: Component codes depend on `ratio_sel`. When `ratio_sel` is 0, blank is 256 and sync is 12. When `ratio_sel` is 1, blank is 240 and sync is 8.
- R3: Composite codes depend on `fmt_sel`. The encodings are 00 NTSC, 01 PAL-M, 10 PAL-B/D/G/H/I and 11 PAL-N. Codes 00 and 01 give blank 240 and sync 8. Codes 10 and 11 give blank 256 and sync 12.
- R4: `out_mode` selects the channel routing.
  - 00 is luma plus colour difference. Channel 0 receives blank and sync. Channels 1 and 2 pass their inputs through unchanged.
  - 01 is RGB with sync on green. All three channels receive blank, and only channel 0 (green) receives sync.
  - 10 and 11 are RGB with a separate sync wire. All three channels receive blank and none receives sync.
  - The composite output always receives blank and sync.
- R5: A ramp counter k runs from 0 to 4. It rises by 1 on each cycle that `sync_act` is 1 and falls by 1 on each cycle that `sync_act` is 0. A channel that receives sync outputs the level blank − (blank − sync)·k/4, where k is the value after this cycle's update.
- R6: The pedestal enable is captured only when the current line is a start line: line 25 of field 0 (`field_id` 0), or line 288 of field 1. On a start line, the enable takes effect in the same cycle. At any other line, changes to `ped_en` have no effect.
- R7: The pedestal applies only while `blank_act` is 0 and the line is inside its field's window: lines 25..262 for field 0 and lines 288..525 for field 1. The heights are 7-bit two's-complement values from −64 to +63 with a gain of 1 code per step. `ped_hgt_comp` drives the component channels that receive blank. `ped_hgt_cvbs` drives the composite output.
- R8: Outside blanking, an offset channel outputs input + level + pedestal. While `blank_act` is 1, the input sample is replaced by 0.
- R9: Results above 1023 clamp to 1023, and results below 0 clamp to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in0 | input | 10 | Component channel 0 sample (luma or green) |
| comp_in1 | input | 10 | Component channel 1 sample (Pb or blue) |
| comp_in2 | input | 10 | Component channel 2 sample (Pr or red) |
| cvbs_in | input | 10 | Composite luma sample |
| sync_act | input | 1 | Sync interval flag |
| blank_act | input | 1 | Blanking interval flag |
| field_id | input | 1 | 0 for field 1, 1 for field 2 |
| line_num | input | 10 | Current line number |
| fmt_sel | input | 2 | Composite video format |
| ratio_sel | input | 1 | Component sync/blank ratio select |
| out_mode | input | 2 | Component channel routing |
| ped_en | input | 1 | Pedestal request, sampled on start lines |
| ped_hgt_cvbs | input | 7 | Composite pedestal height, signed |
| ped_hgt_comp | input | 7 | Component pedestal height, signed |
| dac_c0 | output | 10 | Component channel 0 DAC code |
| dac_c1 | output | 10 | Component channel 1 DAC code |
| dac_c2 | output | 10 | Component channel 2 DAC code |
| dac_cvbs | output | 10 | Composite luma DAC code |

## Verification
The level assertions assume that the control inputs do not change between the edge that captures them and the edge at which their result is checked. The stimulus therefore changes all inputs only once per cycle, shortly after a rising edge. The full-sync check on the composite output also assumes that `blank_act` is high whenever the ramp has reached its tip, and the sync stimulus never raises `sync_act` outside blanking. The stimulus keeps line numbers below 526 and changes `field_id` only between lines. This keeps the pedestal windows consistent with the interlaced line count that the block assumes.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic [1:0] {
    OM_YPBPR   = 2'b00,
    OM_RGB_SOG = 2'b01,
    OM_RGB_EXT = 2'b10,
    OM_RGB_EX2 = 2'b11
  } out_mode_e;

  // component path levels keyed by the ratio select
  function automatic int comp_blank(input logic ratio);
    return ratio ? 240 : 256;
  endfunction

  function automatic int comp_sync(input logic ratio);
    return ratio ? 8 : 12;
  endfunction

  // composite levels: the two 525-line formats sit in codes 00/01
  function automatic int cvbs_blank(input logic [1:0] fmt);
    return fmt[1] ? 256 : 240;
  endfunction

  function automatic int cvbs_sync(input logic [1:0] fmt);
    return fmt[1] ? 12 : 8;
  endfunction

  // linear step from blank (k=0) down to sync (k=len)
  function automatic int ramp_level(input int blank, input int sync, input int k, input int len);
    return blank - ((blank - sync) * k) / len;
  endfunction

  function automatic int clamp_code(input int v, input int maxv);
    if (v < 0)         return 0;
    else if (v > maxv) return maxv;
    else               return v;
  endfunction

endpackage

// File: rtl/vbs_sync_ramp.sv
module vbs_sync_ramp #(
  parameter int RAMP_LEN = 4,
  localparam int KW = $clog2(RAMP_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_act,
  output logic [KW-1:0] k_next,
  output logic [KW-1:0] k_q
);

  localparam logic [KW-1:0] KMAX = KW'(RAMP_LEN);

  always_comb begin
    k_next = k_q;
    if (sync_act && k_q != KMAX)      k_next = k_q + 1'b1;
    else if (!sync_act && k_q != '0)  k_next = k_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_q <= '0;
    else        k_q <= k_next;
  end

endmodule

// File: rtl/vbs_ped_ctl.sv
module vbs_ped_ctl #(
  parameter int LINE_W   = 10,
  parameter int F1_START = 25,
  parameter int F1_END   = 262,
  parameter int F2_START = 288,
  parameter int F2_END   = 525
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_id,
  input  logic [LINE_W-1:0] line_num,
  input  logic              ped_en,
  output logic              start_hit,
  output logic              ped_lat,
  output logic              ped_on
);

  localparam logic [LINE_W-1:0] S1 = LINE_W'(F1_START);
  localparam logic [LINE_W-1:0] E1 = LINE_W'(F1_END);
  localparam logic [LINE_W-1:0] S2 = LINE_W'(F2_START);
  localparam logic [LINE_W-1:0] E2 = LINE_W'(F2_END);

  logic in_win;
  logic ped_eff;

  assign start_hit = field_id ? (line_num == S2) : (line_num == S1);
  assign in_win    = field_id ? (line_num >= S2 && line_num <= E2)
                              : (line_num >= S1 && line_num <= E1);
  // the start line itself already honours the fresh request
  assign ped_eff   = start_hit ? ped_en : ped_lat;
  assign ped_on    = ped_eff && in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ped_lat <= 1'b0;
    else if (start_hit) ped_lat <= ped_en;
  end

endmodule

// File: rtl/vbs_lane.sv
module vbs_lane
  import vbs_pkg::*;
#(
  parameter int DW       = 10,
  parameter int HW       = 7,
  parameter int GAIN     = 1,
  parameter int RAMP_LEN = 4,
  localparam int KW      = $clog2(RAMP_LEN + 1),
  localparam int CMAX    = (1 << DW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          offs_en,
  input  logic          sync_en,
  input  logic          ped_on,
  input  logic [HW-1:0] ped_hgt,
  input  logic          blank_act,
  input  logic [KW-1:0] k,
  input  logic [DW-1:0] blank_code,
  input  logic [DW-1:0] sync_code,
  output logic [DW-1:0] dout
);

  int level;
  int data;
  int total;

  always_comb begin
    level = sync_en ? ramp_level(int'(blank_code), int'(sync_code), int'(k), RAMP_LEN)
                    : int'(blank_code);
    data  = blank_act ? 0
                      : int'(din) + (ped_on ? int'($signed(ped_hgt)) * GAIN : 0);
    total = offs_en ? (level + data) : int'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= DW'(clamp_code(total, CMAX));
  end

endmodule

// File: rtl/vbs_level_inserter.sv
module vbs_level_inserter
  import vbs_pkg::*;
#(
  parameter int DW       = 10,
  parameter int HW       = 7,
  parameter int LINE_W   = 10,
  parameter int GAIN     = 1,
  parameter int RAMP_LEN = 4,
  parameter int N_COMP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     comp_in0,
  input  logic [DW-1:0]     comp_in1,
  input  logic [DW-1:0]     comp_in2,
  input  logic [DW-1:0]     cvbs_in,
  input  logic              sync_act,
  input  logic              blank_act,
  input  logic              field_id,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        fmt_sel,
  input  logic              ratio_sel,
  input  logic [1:0]        out_mode,
  input  logic              ped_en,
  input  logic [HW-1:0]     ped_hgt_cvbs,
  input  logic [HW-1:0]     ped_hgt_comp,
  output logic [DW-1:0]     dac_c0,
  output logic [DW-1:0]     dac_c1,
  output logic [DW-1:0]     dac_c2,
  output logic [DW-1:0]     dac_cvbs
);

  localparam int KW = $clog2(RAMP_LEN + 1);

  logic [KW-1:0] ramp_k;
  logic [KW-1:0] ramp_k_q;
  logic          ped_start_hit;
  logic          ped_lat;
  logic          ped_on;
  logic          rgb_mode;
  logic          luma_sync;
  logic [DW-1:0] cb_code, cs_code, vb_code, vs_code;
  logic [DW-1:0] cin  [N_COMP];
  logic [DW-1:0] cout [N_COMP];

  assign rgb_mode  = (out_mode != OM_YPBPR);
  assign luma_sync = (out_mode == OM_YPBPR) || (out_mode == OM_RGB_SOG);
  assign cb_code   = DW'(comp_blank(ratio_sel));
  assign cs_code   = DW'(comp_sync(ratio_sel));
  assign vb_code   = DW'(cvbs_blank(fmt_sel));
  assign vs_code   = DW'(cvbs_sync(fmt_sel));

  assign cin[0] = comp_in0;
  assign cin[1] = comp_in1;
  assign cin[2] = comp_in2;
  assign dac_c0 = cout[0];
  assign dac_c1 = cout[1];
  assign dac_c2 = cout[2];

  vbs_sync_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
    .clk(clk), .rst_n(rst_n), .sync_act(sync_act),
    .k_next(ramp_k), .k_q(ramp_k_q)
  );

  vbs_ped_ctl #(.LINE_W(LINE_W)) u_ped (
    .clk(clk), .rst_n(rst_n), .field_id(field_id), .line_num(line_num),
    .ped_en(ped_en), .start_hit(ped_start_hit), .ped_lat(ped_lat), .ped_on(ped_on)
  );

  for (genvar i = 0; i < N_COMP; i++) begin : g_comp
    // channel 0 is luma/green: always offset, takes sync unless sync is external
    localparam bit IS_LUMA = (i == 0);
    logic offs_en, sync_en;
    assign offs_en = IS_LUMA ? 1'b1 : rgb_mode;
    assign sync_en = IS_LUMA ? luma_sync : 1'b0;

    vbs_lane #(.DW(DW), .HW(HW), .GAIN(GAIN), .RAMP_LEN(RAMP_LEN)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(cin[i]), .offs_en(offs_en), .sync_en(sync_en),
      .ped_on(ped_on), .ped_hgt(ped_hgt_comp), .blank_act(blank_act), .k(ramp_k),
      .blank_code(cb_code), .sync_code(cs_code), .dout(cout[i])
    );
  end

  vbs_lane #(.DW(DW), .HW(HW), .GAIN(GAIN), .RAMP_LEN(RAMP_LEN)) u_cvbs (
    .clk(clk), .rst_n(rst_n), .din(cvbs_in), .offs_en(1'b1), .sync_en(1'b1),
    .ped_on(ped_on), .ped_hgt(ped_hgt_cvbs), .blank_act(blank_act), .k(ramp_k),
    .blank_code(vb_code), .sync_code(vs_code), .dout(dac_cvbs)
  );

endmodule

// File: rtl/vbs_level_chk.sv
module vbs_level_chk #(
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blank_act,
  input logic [1:0]    out_mode,
  input logic          ratio_sel,
  input logic [1:0]    fmt_sel,
  input logic [9:0]    comp_in1,
  input logic [9:0]    dac_c0,
  input logic [9:0]    dac_c1,
  input logic [9:0]    dac_cvbs,
  input logic [KW-1:0] ramp_k_q,
  input logic          ped_start_hit,
  input logic          ped_lat
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5: ramp moves by at most one step per sample and never passes its tip
  a_r5_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (ramp_k_q <= 3'd4) &&
      ((ramp_k_q == $past(ramp_k_q)) || (ramp_k_q == $past(ramp_k_q) + 3'd1) ||
       ($past(ramp_k_q) == ramp_k_q + 3'd1)));

  // R4: separate-sync RGB keeps green at the blank level throughout blanking
  a_r4_ext_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(blank_act && out_mode[1])) |->
      (dac_c0 == ($past(ratio_sel) ? 10'd240 : 10'd256)));

  // R4: colour-difference channels pass straight through
  a_r4_chroma_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(out_mode == 2'b00)) |-> (dac_c1 == $past(comp_in1)));

  // R3: composite reaches the format's sync tip when the ramp is complete
  a_r3_cvbs_tip: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ramp_k_q == 3'd4 && $past(blank_act)) |->
      (dac_cvbs == ($past(fmt_sel[1]) ? 10'd12 : 10'd8)));

  // R6: pedestal state only changes on a start line
  a_r6_ped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ped_start_hit)) |-> (ped_lat == $past(ped_lat)));

endmodule

bind vbs_level_inserter vbs_level_chk #(.KW(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_act(blank_act), .out_mode(out_mode),
  .ratio_sel(ratio_sel), .fmt_sel(fmt_sel), .comp_in1(comp_in1),
  .dac_c0(dac_c0), .dac_c1(dac_c1), .dac_cvbs(dac_cvbs),
  .ramp_k_q(ramp_k_q), .ped_start_hit(ped_start_hit), .ped_lat(ped_lat)
);

// File: tb/tb_vbs_level_inserter.sv
module tb_vbs_level_inserter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] comp_in0 = '0, comp_in1 = '0, comp_in2 = '0, cvbs_in = '0;
  logic       sync_act = 1'b0, blank_act = 1'b0, field_id = 1'b0;
  logic [9:0] line_num = 10'd10;
  logic [1:0] fmt_sel = 2'b00;
  logic       ratio_sel = 1'b0;
  logic [1:0] out_mode = 2'b00;
  logic       ped_en = 1'b0;
  logic [6:0] ped_hgt_cvbs = '0, ped_hgt_comp = '0;
  logic [9:0] dac_c0, dac_c1, dac_c2, dac_cvbs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vbs_level_inserter dut (.*);

  typedef struct packed {
    logic [1:0] mode;
    logic       ratio;
    logic [1:0] fmt;
    logic       blank;
    logic [9:0] y;
    logic [9:0] exp_c0;
    logic [9:0] exp_cv;
  } vec_t;

  // no sync, line 10 of field 0 (outside pedestal window)
  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 2'b00, 1'b1, 10'd500,  10'd256,  10'd240},
    '{2'b00, 1'b1, 2'b10, 1'b1, 10'd500,  10'd240,  10'd256},
    '{2'b00, 1'b0, 2'b01, 1'b0, 10'd100,  10'd356,  10'd340},
    '{2'b01, 1'b1, 2'b11, 1'b0, 10'd300,  10'd540,  10'd556},
    '{2'b10, 1'b0, 2'b00, 1'b0, 10'd1000, 10'd1023, 10'd1023},
    '{2'b00, 1'b1, 2'b10, 1'b0, 10'd0,    10'd240,  10'd256}
  };

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // apply inputs shortly after a rising edge; results appear after the next edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bl, sy, cbl, csy, k;
    comp_in1 = 10'd100;
    comp_in2 = 10'd200;
    repeat (3) tick();
    chk("R1 reset c0", dac_c0, 10'd0);
    chk("R1 reset c1", dac_c1, 10'd0);
    chk("R1 reset cvbs", dac_cvbs, 10'd0);
    rst_n = 1'b1;

    // R2/R3/R8/R9/R4 table walk
    for (int i = 0; i < NV; i++) begin
      out_mode = TBL[i].mode; ratio_sel = TBL[i].ratio; fmt_sel = TBL[i].fmt;
      blank_act = TBL[i].blank; comp_in0 = TBL[i].y; cvbs_in = TBL[i].y;
      tick();
      chk("R2 R8 R9 table c0", dac_c0, TBL[i].exp_c0);
      chk("R3 R8 R9 table cvbs", dac_cvbs, TBL[i].exp_cv);
    end

    // R1 latency: a new input does not show before the next edge
    comp_in0 = 10'd10;
    #1;
    chk("R1 latency hold", dac_c0, 10'd240);
    tick();
    chk("R1 latency update", dac_c0, 10'd250);

    // R4 routing
    out_mode = 2'b00; blank_act = 1'b0; comp_in1 = 10'd77; comp_in2 = 10'd88;
    tick();
    chk("R4 ypbpr pass c1", dac_c1, 10'd77);
    chk("R4 ypbpr pass c2", dac_c2, 10'd88);
    out_mode = 2'b01; ratio_sel = 1'b0;
    tick();
    chk("R4 rgb c1 blank", dac_c1, 10'd333);
    chk("R4 rgb c2 blank", dac_c2, 10'd344);

    // R5 ramp with sync on green, composite NTSC
    out_mode = 2'b01; ratio_sel = 1'b0; fmt_sel = 2'b00; blank_act = 1'b1;
    sync_act = 1'b0;
    repeat (5) tick();
    cbl = 256; csy = 12; bl = 240; sy = 8; k = 0;
    sync_act = 1'b1;
    for (int n = 0; n < 6; n++) begin
      tick();
      if (k < 4) k++;
      chk("R5 ramp fall c0", dac_c0, 10'(cbl - ((cbl - csy) * k) / 4));
      chk("R5 ramp fall cvbs", dac_cvbs, 10'(bl - ((bl - sy) * k) / 4));
      chk("R4 sog c1 no sync", dac_c1, 10'd256);
    end
    sync_act = 1'b0;
    for (int n = 0; n < 5; n++) begin
      tick();
      if (k > 0) k--;
      chk("R5 ramp rise c0", dac_c0, 10'(cbl - ((cbl - csy) * k) / 4));
      chk("R5 ramp rise cvbs", dac_cvbs, 10'(bl - ((bl - sy) * k) / 4));
    end

    // R4 external sync: green stays at blank during sync
    out_mode = 2'b10; sync_act = 1'b1;
    repeat (5) tick();
    chk("R4 ext sync c0", dac_c0, 10'd256);
    chk("R3 cvbs tip ntsc", dac_cvbs, 10'd8);
    sync_act = 1'b0;
    repeat (5) tick();

    // R6/R7 pedestal
    out_mode = 2'b00; ratio_sel = 1'b0; fmt_sel = 2'b00; blank_act = 1'b0;
    comp_in0 = 10'd100; cvbs_in = 10'd100;
    ped_hgt_comp = 7'd10; ped_hgt_cvbs = 7'h7B;   // +10, -5
    field_id = 1'b0; line_num = 10'd25; ped_en = 1'b1;
    tick();
    chk("R6 start line f1 c0", dac_c0, 10'd366);
    chk("R7 start line f1 cvbs", dac_cvbs, 10'd335);
    line_num = 10'd100; ped_en = 1'b0;
    tick();
    chk("R6 enable ignored mid field", dac_c0, 10'd366);
    blank_act = 1'b1;
    tick();
    chk("R7 no pedestal in blanking", dac_c0, 10'd256);
    blank_act = 1'b0; line_num = 10'd263;
    tick();
    chk("R7 past field1 window", dac_c0, 10'd356);
    field_id = 1'b1; line_num = 10'd287;
    tick();
    chk("R7 before field2 window", dac_cvbs, 10'd340);
    line_num = 10'd288; ped_en = 1'b0;
    tick();
    chk("R6 start line f2 off", dac_c0, 10'd356);
    line_num = 10'd300; ped_en = 1'b1;
    tick();
    chk("R6 late enable ignored", dac_c0, 10'd356);
    line_num = 10'd288;
    tick();
    line_num = 10'd525; ped_en = 1'b0;
    tick();
    chk("R7 field2 window end c0", dac_c0, 10'd366);
    chk("R7 field2 window end cvbs", dac_cvbs, 10'd335);
    ped_hgt_comp = 7'h40;   // -64
    tick();
    chk("R7 negative height", dac_c0, 10'd292);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule